// File: doc/BRIEF.md
# STN Panel Refresh Controller

This block keeps a monochrome STN panel refreshed from a frame buffer in on-chip memory. Software programs it through a byte-wide write port. The settings are:

- the start address of the frame buffer;
- the distance in bytes between the starts of two lines (page width);
- the last beat index of a line and the last line index of a frame;
- a pixel skip count;
- the bus width;
- the polarity-toggle period;
- a power bit and an invert bit;
- an 8-bit general-purpose output latch.

Once powered, the controller walks the frame line by line and reads display bytes through a read-only memory port with one cycle of read latency. It shifts pixels out most significant bit first, on one data line or on four. Around the pixel data it produces a shift clock, a line pulse, a frame marker and a polarity signal.

All outputs share one 8-bit pin group, laid out as follows:

| Pin | Role |
|-----|------|
| 0 | shift clock |
| 1 | line pulse |
| 2 | frame marker |
| 3 | polarity |
| 7..4 | data |

With power off, or on data pins the 1-bit bus leaves unused, the pins show the latch instead. Pins are registered, so they reflect the internal state of the previous cycle.

Register offsets on `reg_addr`:

| Offset | Register |
|--------|----------|
| 0 | start address, low byte |
| 1 | start address, high byte |
| 2 | page width |
| 3 | last beat index |
| 4 | last line index |
| 5 | skip count, bits 2..0 |
| 6 | control: bit 7 power, bit 0 invert |
| 7 | mode: bit 4 selects the 4-bit bus |
| 8 | polarity period, bits 4..0 |
| 9 | port latch |

Top module: `lcd_refresh`

## Requirements
- R1: After reset, `lcd_pins` reads 0xFF because the port latch resets to 0xFF. All other settings reset to zero. With only the power bit then set, line 0 shows one 1-bit pixel read from address 0.
- R2: While the power bit (offset 6, bit 7) is clear, `lcd_pins` equals the port latch, one cycle after the latch or power write takes effect.
- R3: Pixel k of line n is bit 7-((s+k) mod 8) of the byte at start + n*width + (s+k)/8, where s is the skip count. Addresses wrap modulo 2^16.
- R4: With mode bit 4 clear, one pixel per beat appears on pin 4. With it set, four pixels per beat appear on pins 7..4, the first of them on pin 7.
- R5: On the 1-bit bus, pins 7..5 follow port latch bits 7..5 while the panel is powered.
- R6: With control bit 0 set, every pixel bit driven during a beat is inverted. Outside beats the data pins driven by the controller are 0.
- R7: Each beat lasts two cycles with the data held. In the first cycle the shift clock is high; in the second it is low. A line has last-beat-index+1 beats on the 1-bit bus, or floor(index/4)+1 beats on the 4-bit bus. The line pulse is high for the two cycles after the last beat, and the shift clock is low during it. Three quiet cycles separate lines, and four quiet cycles follow power-on.
- R8: The frame marker rises in the cycle after the line pulse of the last line ends. It falls in the cycle after the next line pulse ends.
- R9: For a period P from 1 to 31, the polarity pin toggles in the cycle after every P-th line pulse ends, counted from power-on.
- R10: For a period of 0, the polarity pin toggles in the same cycle as each rise of the frame marker.
- R11: Clearing power mid-frame discards the scan position, the frame marker and the polarity state. The next power-on restarts at line 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| mem_addr | output | 16 | Display memory read address |
| mem_rdata | input | 8 | Display memory data, one cycle after the address |
| lcd_pins | output | 8 | Shared panel and port pins |

## Verification
The bench targets these corner cases:

- **Skip count 7 on the 4-bit bus.** Each beat straddles two bytes, so a window that does not carry into the next byte shows stale bits on the low data pins.
- **Single-line frames.** The frame marker must stay high, and a period of 31 checks that the line counter neither saturates nor wraps early.
- **Frame buffer starting at 0xFFFF.** A wrong modulo-2^16 wrap fetches the wrong second byte.
- **Power cut mid-frame.** A design that keeps its line count or polarity across the cut misplaces the frame marker and polarity on the next run.

On the 1-bit bus the bench also checks that the latch bits stay on the unused data pins throughout.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  localparam int LCD_AW   = 16;
  localparam int LCD_BW   = 8;
  localparam int LCD_PANW = 3;
  localparam int LCD_ACW  = 5;
  localparam int LCD_NPIN = 8;
  localparam int LCD_DATW = 4;

  localparam logic [3:0] RA_START_LO = 4'd0;
  localparam logic [3:0] RA_START_HI = 4'd1;
  localparam logic [3:0] RA_PAGEW    = 4'd2;
  localparam logic [3:0] RA_XLAST    = 4'd3;
  localparam logic [3:0] RA_YLAST    = 4'd4;
  localparam logic [3:0] RA_SKIP     = 4'd5;
  localparam logic [3:0] RA_CTRL     = 4'd6;
  localparam logic [3:0] RA_MODE     = 4'd7;
  localparam logic [3:0] RA_ACPER    = 4'd8;
  localparam logic [3:0] RA_PORT     = 4'd9;

  localparam int CTRL_PWR_BIT  = 7;
  localparam int CTRL_INV_BIT  = 0;
  localparam int MODE_WIDE_BIT = 4;

  localparam int PIN_SCLK  = 0;
  localparam int PIN_LINE  = 1;
  localparam int PIN_FRAME = 2;
  localparam int PIN_POL   = 3;
  localparam int PIN_DAT0  = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE0, ST_PRE1, ST_PRE2, ST_BEAT_HI, ST_BEAT_LO, ST_LINE_A, ST_LINE_B
  } scan_st_t;

  typedef struct packed {
    logic [LCD_AW-1:0]   start;
    logic [LCD_BW-1:0]   pagew;
    logic [LCD_BW-1:0]   xlast;
    logic [LCD_BW-1:0]   ylast;
    logic [LCD_PANW-1:0] skip;
    logic                pwr;
    logic                inv;
    logic                wide;
    logic [LCD_ACW-1:0]  acper;
    logic [LCD_BW-1:0]   port;
  } lcd_cfg_t;
endpackage

// File: rtl/lcd_regs.sv
module lcd_regs
  import lcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [3:0]        addr,
  input  logic [LCD_BW-1:0] wdata,
  output lcd_cfg_t          cfg
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg      <= '0;
      cfg.port <= '1;
    end else if (we) begin
      case (addr)
        RA_START_LO: cfg.start[LCD_BW-1:0]      <= wdata;
        RA_START_HI: cfg.start[LCD_AW-1:LCD_BW] <= wdata;
        RA_PAGEW:    cfg.pagew <= wdata;
        RA_XLAST:    cfg.xlast <= wdata;
        RA_YLAST:    cfg.ylast <= wdata;
        RA_SKIP:     cfg.skip  <= wdata[LCD_PANW-1:0];
        RA_CTRL: begin
          cfg.pwr <= wdata[CTRL_PWR_BIT];
          cfg.inv <= wdata[CTRL_INV_BIT];
        end
        RA_MODE:     cfg.wide  <= wdata[MODE_WIDE_BIT];
        RA_ACPER:    cfg.acper <= wdata[LCD_ACW-1:0];
        RA_PORT:     cfg.port  <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lcd_scan.sv
module lcd_scan
  import lcd_pkg::*;
#(
  parameter int AW  = LCD_AW,
  parameter int ACW = LCD_ACW
) (
  input  logic          clk,
  input  logic          rst,
  input  lcd_cfg_t      cfg,
  input  logic          byte_used,
  output scan_st_t      st,
  output logic [AW-1:0] mem_addr,
  output logic          frame_mk,
  output logic          pol
);
  logic [LCD_BW-1:0]  beat_cnt, line_cnt, beat_last;
  logic [AW-1:0]      line_base, next_base;
  logic [ACW-1:0]     pol_cnt;
  logic               last_line;

  assign beat_last = cfg.wide ? {2'b00, cfg.xlast[LCD_BW-1:2]} : cfg.xlast;
  assign last_line = (line_cnt == cfg.ylast);
  assign next_base = last_line ? cfg.start : line_base + AW'(cfg.pagew);

  always_ff @(posedge clk) begin
    if (rst || !cfg.pwr) begin
      st        <= ST_IDLE;
      beat_cnt  <= '0;
      line_cnt  <= '0;
      line_base <= '0;
      mem_addr  <= '0;
      frame_mk  <= 1'b0;
      pol       <= 1'b0;
      pol_cnt   <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          st        <= ST_PRE0;
          line_base <= cfg.start;
          mem_addr  <= cfg.start;
          line_cnt  <= '0;
        end
        ST_PRE0: begin
          st       <= ST_PRE1;
          mem_addr <= mem_addr + 1'b1;
        end
        ST_PRE1: begin
          st       <= ST_PRE2;
          mem_addr <= mem_addr + 1'b1;
        end
        ST_PRE2: begin
          st       <= ST_BEAT_HI;
          beat_cnt <= '0;
        end
        ST_BEAT_HI: st <= ST_BEAT_LO;
        ST_BEAT_LO: begin
          if (byte_used) mem_addr <= mem_addr + 1'b1;
          if (beat_cnt == beat_last) begin
            st <= ST_LINE_A;
          end else begin
            st       <= ST_BEAT_HI;
            beat_cnt <= beat_cnt + 1'b1;
          end
        end
        ST_LINE_A: st <= ST_LINE_B;
        default: begin
          st        <= ST_PRE0;
          frame_mk  <= last_line;
          line_cnt  <= last_line ? '0 : line_cnt + 1'b1;
          line_base <= next_base;
          mem_addr  <= next_base;
          if (cfg.acper == '0) begin
            if (last_line) pol <= ~pol;
          end else if (pol_cnt + 1'b1 == cfg.acper) begin
            pol     <= ~pol;
            pol_cnt <= '0;
          end else begin
            pol_cnt <= pol_cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/lcd_serial.sv
module lcd_serial
  import lcd_pkg::*;
#(
  parameter int PANW = LCD_PANW,
  parameter int BW   = LCD_BW,
  parameter int DATW = LCD_DATW
) (
  input  logic            clk,
  input  logic            rst,
  input  scan_st_t        st,
  input  logic            wide,
  input  logic [PANW-1:0] skip,
  input  logic [BW-1:0]   rdata,
  output logic [DATW-1:0] data,
  output logic            byte_used
);
  localparam int SUMW = PANW + 1;
  localparam int WINW = 2 * BW;

  logic [BW-1:0]   cur, nxt;
  logic [PANW-1:0] ptr;
  logic [SUMW-1:0] sum;
  logic [WINW-1:0] win;

  assign sum       = {1'b0, ptr} + (wide ? SUMW'(DATW) : SUMW'(1));
  assign byte_used = (st == ST_BEAT_LO) && sum[PANW];
  assign win       = {cur, nxt} << ptr;
  assign data      = wide ? win[WINW-1 -: DATW] : {{(DATW-1){1'b0}}, win[WINW-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= '0;
      nxt <= '0;
      ptr <= '0;
    end else begin
      case (st)
        ST_PRE1: cur <= rdata;
        ST_PRE2: begin
          nxt <= rdata;
          ptr <= skip;
        end
        ST_BEAT_LO: begin
          ptr <= sum[PANW-1:0];
          if (sum[PANW]) begin
            cur <= nxt;
            nxt <= rdata;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lcd_pinmux.sv
module lcd_pinmux
  import lcd_pkg::*;
#(
  parameter int NPIN = LCD_NPIN,
  parameter int DATW = LCD_DATW
) (
  input  logic            clk,
  input  logic            rst,
  input  lcd_cfg_t        cfg,
  input  scan_st_t        st,
  input  logic [DATW-1:0] data,
  input  logic            frame_mk,
  input  logic            pol,
  output logic [NPIN-1:0] pins
);
  logic [DATW-1:0] flip, dat;
  logic [NPIN-1:0] view;
  logic            beat;

  always_comb begin
    beat = (st == ST_BEAT_HI) || (st == ST_BEAT_LO);
    flip = cfg.inv ? (cfg.wide ? '1 : DATW'(1)) : '0;
    dat  = beat ? (data ^ flip) : '0;
    view = '0;
    view[PIN_SCLK]  = (st == ST_BEAT_HI);
    view[PIN_LINE]  = (st == ST_LINE_A) || (st == ST_LINE_B);
    view[PIN_FRAME] = frame_mk;
    view[PIN_POL]   = pol;
    view[NPIN-1:PIN_DAT0] = cfg.wide ? dat : {cfg.port[NPIN-1:PIN_DAT0+1], dat[0]};
  end

  always_ff @(posedge clk) begin
    if (rst) pins <= '1;
    else     pins <= cfg.pwr ? view : cfg.port;
  end
endmodule

// File: rtl/lcd_refresh.sv
module lcd_refresh
  import lcd_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_we,
  input  logic [3:0]          reg_addr,
  input  logic [LCD_BW-1:0]   reg_wdata,
  output logic [LCD_AW-1:0]   mem_addr,
  input  logic [LCD_BW-1:0]   mem_rdata,
  output logic [LCD_NPIN-1:0] lcd_pins
);
  lcd_cfg_t              cfg;
  scan_st_t              st;
  logic [LCD_DATW-1:0]   data;
  logic                  byte_used, frame_mk, pol, pwr_on;
  logic [LCD_BW-1:0]     port_lat;

  assign pwr_on   = cfg.pwr;
  assign port_lat = cfg.port;

  lcd_regs u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata), .cfg(cfg)
  );

  lcd_scan u_scan (
    .clk(clk), .rst(rst), .cfg(cfg), .byte_used(byte_used), .st(st),
    .mem_addr(mem_addr), .frame_mk(frame_mk), .pol(pol)
  );

  lcd_serial u_serial (
    .clk(clk), .rst(rst), .st(st), .wide(cfg.wide), .skip(cfg.skip),
    .rdata(mem_rdata), .data(data), .byte_used(byte_used)
  );

  lcd_pinmux u_pins (
    .clk(clk), .rst(rst), .cfg(cfg), .st(st), .data(data),
    .frame_mk(frame_mk), .pol(pol), .pins(lcd_pins)
  );
endmodule

// File: rtl/lcd_refresh_chk.sv
module lcd_refresh_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] pins,
  input logic       pwr,
  input logic [7:0] port
);
  assert_port_fallback_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(pwr) |-> (pins == $past(port)));

  assert_line_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(pwr) && pins[1]) |-> !pins[0]);

  assert_beat_hold_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(pwr, 2) && $past(pwr) && $past(pins[0]))
      |-> (!pins[0] && pins[4] == $past(pins[4])));

  assert_frame_edge_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(pwr, 2) && $past(pwr) && pins[2] != $past(pins[2]))
      |-> ($past(pins[1]) && !pins[1]));

  assert_pol_edge_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(pwr, 2) && $past(pwr) && pins[3] != $past(pins[3]))
      |-> ($past(pins[1]) && !pins[1]));
endmodule

bind lcd_refresh lcd_refresh_chk i_chk (
  .clk(clk), .rst(rst), .pins(lcd_pins), .pwr(pwr_on), .port(port_lat)
);

// File: tb/test_lcd_refresh.sv
module test_lcd_refresh;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic [7:0]  pins;

  int n_chk = 0;
  int n_err = 0;

  logic [15:0] s_start = '0;
  int          s_vpw = 0, s_xl = 0, s_yl = 0, s_skip = 0, s_acp = 0;
  bit          s_wide = 0, s_inv = 0;
  logic [7:0]  s_port = 8'hFF;
  string       s_tag = "";

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PER/2) clk = ~clk;

  function automatic logic [7:0] memf(input logic [15:0] a);
    logic [7:0] v;
    v = a[7:0] * 8'd37 + a[15:8] * 8'd11 + 8'h5A;
    return v;
  endfunction

  always_ff @(posedge clk) mem_rdata <= memf(mem_addr);

  lcd_refresh i_lcd_refresh (
    .clk(clk), .rst(rst), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .lcd_pins(pins)
  );

  task automatic chk(input string rq, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%h exp=%h at %0t", rq, got, exp, $time);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    we = 1'b1; addr = 4'(a); wdata = 8'(d);
    @(negedge clk);
    we = 1'b0;
  endtask

  function automatic logic [7:0] mk(input bit sc, input bit lp, input bit fm, input bit pl,
                                    input logic [3:0] nib);
    logic [7:0] p;
    p[0] = sc; p[1] = lp; p[2] = fm; p[3] = pl;
    p[7:4] = s_wide ? nib : {s_port[7:5], nib[0]};
    return p;
  endfunction

  task automatic push(input logic [7:0] v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  task automatic build(input int nlines);
    bit fm = 0, pl = 0;
    int acc = 0, line = 0;
    repeat (4) push(mk(0, 0, fm, pl, 4'h0), "R7");
    for (int l = 0; l < nlines; l++) begin
      logic [15:0] base;
      int w, nb;
      string dt;
      bit last;
      base = s_start + 16'(line * s_vpw);
      w  = s_wide ? 4 : 1;
      nb = s_wide ? s_xl / 4 + 1 : s_xl + 1;
      dt = (l == 0 && s_tag != "") ? s_tag : s_inv ? "R6" : s_wide ? "R4" : "R3";
      for (int b = 0; b < nb; b++) begin
        logic [3:0] nib = 4'h0;
        for (int j = 0; j < w; j++) begin
          int o;
          logic [7:0] v;
          o = s_skip + b * w + j;
          v = memf(base + 16'(o / 8));
          if (s_wide) nib[3-j] = v[7 - (o % 8)];
          else        nib[0]   = v[7 - (o % 8)];
        end
        if (s_inv) nib = nib ^ (s_wide ? 4'hF : 4'h1);
        push(mk(1, 0, fm, pl, nib), dt);
        push(mk(0, 0, fm, pl, nib), dt);
      end
      repeat (2) push(mk(0, 1, fm, pl, 4'h0), "R7");
      last = (line == s_yl);
      fm = last;
      if (s_acp == 0) begin
        if (last) pl = ~pl;
      end else begin
        acc++;
        if (acc == s_acp) begin pl = ~pl; acc = 0; end
      end
      line = last ? 0 : line + 1;
      repeat (3) push(mk(0, 0, fm, pl, 4'h0), "R7");
    end
  endtask

  task automatic run_model();
    while (exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      @(negedge clk);
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk("R7 clock/line pins", 8'(pins[1:0]), 8'(e[1:0]));
      chk("R8 frame marker", 8'(pins[2]), 8'(e[2]));
      chk(s_acp == 0 ? "R10 polarity" : "R9 polarity", 8'(pins[3]), 8'(e[3]));
      if (s_wide) chk(t, 8'(pins[7:4]), 8'(e[7:4]));
      else begin
        chk(t, 8'(pins[4]), 8'(e[4]));
        chk("R5 unused data pins", 8'(pins[7:5]), 8'(e[7:5]));
      end
    end
  endtask

  task automatic power_off_check();
    wr(6, 0);
    @(negedge clk);
    chk("R2 port fallback", pins, s_port);
  endtask

  task automatic config_and_run(input int nlines);
    wr(0, int'(s_start[7:0])); wr(1, int'(s_start[15:8]));
    wr(2, s_vpw); wr(3, s_xl); wr(4, s_yl); wr(5, s_skip);
    wr(7, s_wide ? 8'h10 : 8'h00); wr(8, s_acp); wr(9, int'(s_port));
    build(nlines);
    wr(6, s_inv ? 8'h81 : 8'h80);
    run_model();
    power_off_check();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog R7 got=hung exp=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset pins", pins, 8'hFF);

    // R1: defaults only, then power on
    s_tag = "R1";
    build(3);
    wr(6, 8'h80);
    run_model();
    power_off_check();
    s_tag = "";

    // R2: latch value while unpowered
    s_port = 8'hA5;
    wr(9, int'(s_port));
    @(negedge clk);
    chk("R2 latch shown", pins, 8'hA5);

    // R3 R5: 1-bit bus, several frames
    s_start = 16'h0100; s_vpw = 4; s_xl = 11; s_yl = 2; s_skip = 0; s_acp = 0;
    s_wide = 0; s_inv = 0;
    config_and_run(8);

    // R4 R6 R9: 4-bit bus, skip 3, inverted, period 2
    s_start = 16'h0200; s_vpw = 3; s_xl = 15; s_yl = 3; s_skip = 3; s_acp = 2;
    s_wide = 1; s_inv = 1; s_port = 8'h3C;
    config_and_run(10);

    // R3 R6: wrap at 0xFFFF, 1-bit, skip 5
    s_start = 16'hFFFF; s_vpw = 200; s_xl = 9; s_yl = 1; s_skip = 5; s_acp = 3;
    s_wide = 0; s_inv = 1; s_port = 8'h5A;
    config_and_run(6);

    // R4 R8 R9: single-line frames, skip 7 straddles bytes, period 1
    s_start = 16'h0340; s_vpw = 2; s_xl = 3; s_yl = 0; s_skip = 7; s_acp = 1;
    s_wide = 1; s_inv = 0;
    config_and_run(5);

    // R9: longest period 31
    s_start = 16'h0400; s_vpw = 1; s_xl = 3; s_yl = 0; s_skip = 2; s_acp = 31;
    config_and_run(64);

    // R11: cut power mid-frame, then restart from line 0
    wr(6, 8'h80);
    repeat (23) @(negedge clk);
    wr(6, 0);
    s_start = 16'h0100; s_vpw = 4; s_xl = 11; s_yl = 2; s_skip = 0; s_acp = 0;
    s_wide = 0; s_inv = 0; s_port = 8'hE1; s_tag = "R11";
    config_and_run(4);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule